// File: doc/BRIEF.md
# Interrupt Level Encoder with Autovector Acknowledge

This block gathers seven active-low interrupt request lines and reduces them to a single 3-bit interrupt level for a processor that takes an encoded level. The request lines may come from backplane attention lines or from an on-board serial controller. Each request line is resynchronised to the block clock before it is encoded. The level output always names the most urgent request that is active and is held in a register, so it moves cleanly from one valid level to the next.

The block also watches the processor's bus-cycle qualifiers. When the function-code lines are all high while address strobe is asserted, the cycle is an interrupt acknowledge. The block answers it by pulling an active-low autovector request. The processor then takes its handler address from its own fixed autovector table, and the block never drives a vector byte. The autovector request is dropped the moment address strobe goes high again.

Top module: `irqLevelEncoder`

## Requirements
- R1: While reset is asserted and right after it is released, `iplN` reads 3'b111 and `autoVecN` reads 1.
- R2: When no request line is low, the encoded level is 0, so `iplN` reads 3'b111.
- R3: When request line n is the highest-numbered low line, the level is n+1 and `iplN` carries its bitwise inverse, so line 0 gives 3'b110 and line 6 gives 3'b000.
- R4: A low request line numbered below the highest active one has no effect on `iplN`.
- R5: A change on `reqN` that is applied between clock edges appears on `iplN` after the third rising edge and not before it: two synchroniser stages plus the output register.
- R6: An interrupt acknowledge is `fcode` == 3'b111 with `asN` low. When it is seen at a rising edge, `autoVecN` goes low after that edge and not before it.
- R7: When `asN` is low and `fcode` is any value other than 3'b111, `autoVecN` stays high.
- R8: Once `asN` returns high, `autoVecN` is high in the same instant, without waiting for a clock edge.
- R9: Once `autoVecN` is low, it stays low for as long as `asN` stays low, even if `fcode` changes during the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqN | input | 7 | Interrupt request lines, active low, line 6 most urgent |
| fcode | input | 3 | Processor function-code lines |
| asN | input | 1 | Processor address strobe, active low |
| iplN | output | 3 | Encoded interrupt level, active low |
| autoVecN | output | 1 | Autovector request to the processor, active low |

## Verification
The bench drives every one of the 128 request patterns and compares `iplN` with a level it computes from the highest low line. A wrong priority direction or an off-by-one mapping would show up on many of those patterns, and the all-inactive pattern catches an encoder that reports line 0 as idle. Latency is checked on both sides of the third edge, so a missing or extra synchroniser stage fails. On the acknowledge side, the bench tries every function-code value, changes `fcode` part-way through an acknowledge, and reads `autoVecN` right after `asN` rises. A decoder that matches too many codes, drops out too early, or releases only on the next clock edge would each be reported.

// File: rtl/irqEncPkg.sv
package irqEncPkg;

  // Strobes passed from the acknowledge control to the datapath.
  typedef struct packed {
    logic ackActive;   // an acknowledge has been latched and is still running
  } ackStrobes_t;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_HELD = 2'd1
  } ackState_t;

endpackage

// File: rtl/irqEncDatapath.sv
module irqEncDatapath
  import irqEncPkg::*;
#(
  parameter int NUM_REQ     = 7,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic               asN,
  input  ackStrobes_t        strobes,
  output logic [LVL_W-1:0]   iplN,
  output logic               autoVecN
);

  // Synchroniser chain: every stage resets to "no request" (all ones).
  logic [NUM_REQ-1:0] syncStage [SYNC_STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[gs] <= '1;
          else       syncStage[gs] <= reqN;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[gs] <= '1;
          else       syncStage[gs] <= syncStage[gs-1];
        end
      end
    end
  endgenerate

  logic [NUM_REQ-1:0] reqSynced;
  assign reqSynced = syncStage[SYNC_STAGES-1];

  // Priority encoder: ascending scan, so the highest active index wins.
  logic [LVL_W-1:0] levelNext;
  always_comb begin
    levelNext = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!reqSynced[i]) levelNext = LVL_W'(i + 1);
    end
  end

  // Registered, inverted level output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) iplN <= '1;
    else       iplN <= ~levelNext;
  end

  // Autovector request: latched by control, released with the strobe.
  assign autoVecN = ~(strobes.ackActive & ~asN);

endmodule

// File: rtl/irqEncControl.sv
module irqEncControl
  import irqEncPkg::*;
#(
  parameter int FC_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [FC_W-1:0] fcode,
  input  logic            asN,
  output ackStrobes_t     strobes
);

  ackState_t stateQ, stateD;
  logic      iackSeen;

  // An acknowledge cycle: all function-code lines high with strobe low.
  assign iackSeen = (&fcode) & ~asN;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ACK_IDLE: if (iackSeen) stateD = ACK_HELD;
      ACK_HELD: if (asN)      stateD = ACK_IDLE;
      default:                stateD = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ACK_IDLE;
    else       stateQ <= stateD;
  end

  assign strobes.ackActive = (stateQ == ACK_HELD);

endmodule

// File: rtl/irqLevelEncoder.sv
module irqLevelEncoder
  import irqEncPkg::*;
#(
  parameter int NUM_REQ     = 7,
  parameter int SYNC_STAGES = 2,
  parameter int FC_W        = 3,
  localparam int LVL_W      = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  logic [FC_W-1:0]    fcode,
  input  logic               asN,
  output logic [LVL_W-1:0]   iplN,
  output logic               autoVecN
);

  ackStrobes_t strobes;

  irqEncControl #(
    .FC_W(FC_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fcode   (fcode),
    .asN     (asN),
    .strobes (strobes)
  );

  irqEncDatapath #(
    .NUM_REQ     (NUM_REQ),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqN     (reqN),
    .asN      (asN),
    .strobes  (strobes),
    .iplN     (iplN),
    .autoVecN (autoVecN)
  );

endmodule

// File: rtl/irqEncChecker.sv
module irqEncChecker #(
  parameter int NUM_REQ     = 7,
  parameter int SYNC_STAGES = 2,
  parameter int FC_W        = 3,
  localparam int LVL_W      = $clog2(NUM_REQ + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqN,
  input logic [FC_W-1:0]    fcode,
  input logic               asN,
  input logic [LVL_W-1:0]   iplN,
  input logic               autoVecN
);

  // Cycles since reset release, saturating; guards the fixed-depth look-back.
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 3) sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic [LVL_W-1:0] expectLevel(logic [NUM_REQ-1:0] lines);
    logic [LVL_W-1:0] lv;
    lv = '0;
    for (int i = 0; i < NUM_REQ; i++) if (!lines[i]) lv = LVL_W'(i + 1);
    return lv;
  endfunction

  // R1: immediately out of reset both outputs are inactive
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rstN) |-> (iplN == '1 && autoVecN));

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      // R3 / R5: level follows the request pattern three edges earlier
      a_r3_level_match: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst == 3) |-> (iplN == ~expectLevel($past(reqN, 3))));
      // R2: no request three edges ago gives level zero
      a_r2_idle_level: assert property (@(posedge clk) disable iff (!rstN)
        (sinceRst == 3 && $past(reqN, 3) == '1) |-> (iplN == '1));
    end
  endgenerate

  // R6: an acknowledge seen at an edge asserts autovector after it
  a_r6_ack_assert: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && (&fcode)) |=> (asN || !autoVecN));

  // R7: autovector only starts after an acknowledge was qualified
  a_r7_only_on_iack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(autoVecN) |-> $past(!asN && (&fcode)));

  // R8: strobe high means autovector released
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> autoVecN);

  // R9: autovector held while strobe stays low
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!autoVecN && !asN) |=> (asN || !autoVecN));

endmodule

bind irqLevelEncoder irqEncChecker #(
  .NUM_REQ     (NUM_REQ),
  .SYNC_STAGES (SYNC_STAGES),
  .FC_W        (FC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqN     (reqN),
  .fcode    (fcode),
  .asN      (asN),
  .iplN     (iplN),
  .autoVecN (autoVecN)
);

// File: tb/test_irqLevelEncoder.sv
module test_irqLevelEncoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] reqN = '1;
  logic [2:0] fcode = '0;
  logic       asN = 1'b1;
  logic [2:0] iplN;
  logic       autoVecN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqLevelEncoder i_irqLevelEncoder (
    .clk      (clk),
    .rstN     (rstN),
    .reqN     (reqN),
    .fcode    (fcode),
    .asN      (asN),
    .iplN     (iplN),
    .autoVecN (autoVecN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] levelOf(logic [6:0] lines);
    logic [2:0] lv = 3'd0;
    for (int i = 6; i >= 0; i--) if (!lines[i]) begin lv = 3'(i + 1); break; end
    return lv;
  endfunction

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitNeg(3);
    // R1: during reset
    check(iplN == 3'b111, "R1 iplN in reset", iplN, 7);
    check(autoVecN == 1'b1, "R1 autoVecN in reset", autoVecN, 1);
    rstN = 1'b1;
    waitNeg(1);
    check(iplN == 3'b111, "R1 iplN after reset", iplN, 7);
    check(autoVecN == 1'b1, "R1 autoVecN after reset", autoVecN, 1);

    // R2 / R3 / R4: sweep every request pattern
    for (int p = 0; p < 128; p++) begin
      logic [2:0] lv;
      reqN = 7'(p);
      lv = levelOf(7'(p));
      waitNeg(4);
      if (p == 127)
        check(iplN == 3'b111, "R2 idle level", iplN, 7);
      else if ($countones(~7'(p)) > 1)
        check(iplN == ~lv, "R4 lower lines ignored", iplN, ~lv);
      else
        check(iplN == ~lv, "R3 single line level", iplN, ~lv);
    end

    // R5: latency from all idle to line 4 (level 5, iplN 3'b010)
    reqN = '1;
    waitNeg(4);
    reqN = 7'b110_1111;
    waitNeg(2);
    check(iplN == 3'b111, "R5 not before third edge", iplN, 7);
    waitNeg(1);
    check(iplN == 3'b010, "R5 on third edge", iplN, 2);
    reqN = '1;
    waitNeg(4);

    // R6: acknowledge timing
    fcode = 3'b111;
    asN = 1'b0;
    #1;
    check(autoVecN == 1'b1, "R6 not before edge", autoVecN, 1);
    waitNeg(1);
    check(autoVecN == 1'b0, "R6 asserted after edge", autoVecN, 0);
    // R9: fcode changes, strobe stays low
    fcode = 3'b010;
    waitNeg(2);
    check(autoVecN == 1'b0, "R9 held while strobe low", autoVecN, 0);
    // R8: immediate release
    asN = 1'b1;
    #1;
    check(autoVecN == 1'b1, "R8 released with strobe", autoVecN, 1);
    waitNeg(2);
    check(autoVecN == 1'b1, "R8 stays released", autoVecN, 1);

    // R7: other function codes never request an autovector
    for (int f = 0; f < 7; f++) begin
      fcode = 3'(f);
      asN = 1'b0;
      waitNeg(2);
      check(autoVecN == 1'b1, "R7 non-acknowledge code", autoVecN, 1);
      asN = 1'b1;
      waitNeg(1);
    end

    // R6: second acknowledge while a request is pending (level unchanged)
    reqN = 7'b011_1111;
    waitNeg(4);
    fcode = 3'b111;
    asN = 1'b0;
    waitNeg(1);
    check(autoVecN == 1'b0, "R6 second acknowledge", autoVecN, 0);
    check(iplN == 3'b000, "R3 level during acknowledge", iplN, 0);
    asN = 1'b1;
    #1;
    check(autoVecN == 1'b1, "R8 second release", autoVecN, 1);
    waitNeg(1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule